// File: doc/BRIEF.md
# PWM Period and Duty Capture

This block measures the period and the high time of a digital input. A free-running counter advances once every `psc_i + 1` clocks and wraps to zero after reaching `arr_i`, so the counter modulus is `arr_i + 1`. One of two input pins is chosen by `sel_i`, passed through a two-flop synchroniser and fed to an edge detector. Two capture channels watch the same synchronised signal. Channel A latches the counter on rising edges. Channel B latches it on falling edges.

A pulse on `start_i` clears the counter, the edge dividers and channel B, and arms the block. Each rising-edge capture while armed emits one `{A, B}` pair on the snapshot stream. The first pair supplies the reference time t0. The second pair supplies t2 (A) and t1 (B). From these the block forms the period t2 − t0 and the duty t1 − t0, both corrected for counter wrap. It then raises `done_o` and holds the results until the next start. An input divider captures only every 1st, 2nd, 4th or 8th edge on both channels. Conversion to time units is left to the consumer.

Top module: `pwm_capture`

## Requirements
- R1: After reset `done_o`, `snap_valid_o`, `period_o` and `duty_o` are all zero.
- R2: The counter steps once every `psc_i + 1` clocks, counts from 0 to `arr_i` and then wraps to 0. A period of P clocks with P a multiple of `psc_i + 1` measures P/(`psc_i` + 1) ticks.
- R3: Channel A holds the counter value at a captured rising edge, and channel B holds it at a captured falling edge. Each snapshot carries A in `snap_rise_o` and the latest B in `snap_fall_o`.
- R4: `sel_i` = 0 measures `pin0_i` and `sel_i` = 1 measures `pin1_i`. Activity on the other pin has no effect on the results.
- R5: Exactly two snapshots are emitted per start. `done_o` rises in the same cycle as the second snapshot is emitted.
- R6: The period equals t2 − t0 when t2 ≥ t0, and otherwise equals (`arr_i` + 1) − t0 + t2.
- R7: The raw duty equals t1 − t0 with the same wrap rule, where t1 is channel B at the second snapshot.
- R8: If the raw duty exceeds the period, the reported duty is the raw duty minus the period.
- R9: `icpsc_i` code k (0 to 3) makes both channels capture only the first of every 2^k edges of their polarity, counted from start. The period then spans 2^k input periods.
- R10: While `done_o` is high and no start arrives, `period_o` and `duty_o` stay constant and no further snapshots are emitted.
- R11: `start_i` clears `done_o` on the next clock and begins a new measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Restart measurement (one-cycle pulse) |
| sel_i | input | 1 | Input pin select |
| pin0_i | input | 1 | Measured input, choice 0 |
| pin1_i | input | 1 | Measured input, choice 1 |
| psc_i | input | PSC_W | Counter clock divider, divides by value + 1 |
| arr_i | input | CNT_W | Counter top value (auto-reload) |
| icpsc_i | input | 2 | Edge divider code: 1, 2, 4 or 8 edges per capture |
| snap_valid_o | output | 1 | Snapshot pair valid |
| snap_rise_o | output | CNT_W | Channel A value of the pair |
| snap_fall_o | output | CNT_W | Channel B value of the pair |
| done_o | output | 1 | Measurement complete, results held |
| period_o | output | CNT_W | Period in counter ticks |
| duty_o | output | CNT_W | High time in counter ticks |

## Verification
Several events can land in the same clock edge. The second rising-edge capture emits a snapshot, closes the measurement and loads both wrap-corrected differences all at once. A stream check and a result check must therefore agree at that edge. The bench also provokes a counter wrap and a duty overflow in the same capture: it uses a short counter modulus and an input whose period exceeds it, so the wrap correction and the duty-minus-period correction both act on one result. That result is compared with values computed from the applied period, high time and modulus.

// File: rtl/pwm_cap_pkg.sv
`timescale 1ns/1ps
package pwm_cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REF  = 2'd1,
    ST_END  = 2'd2,
    ST_DONE = 2'd3
  } cap_state_e;

  localparam int unsigned NUM_CH = 2;  // 0: rising (A), 1: falling (B)
endpackage

// File: rtl/pwm_cap_edge.sv
`timescale 1ns/1ps
module pwm_cap_edge (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  input  logic [1:0] pin_i,
  output logic       rise_o,
  output logic       fall_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin_i[sel_i];
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;
  assign fall_o = ~s2_q & s3_q;
endmodule

// File: rtl/pwm_cap_timebase.sv
`timescale 1ns/1ps
module pwm_cap_timebase #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [CNT_W-1:0] arr_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [PSC_W-1:0] div_q;
  logic             tick;

  assign tick = (div_q >= psc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      cnt_o <= '0;
    end else if (clr_i) begin
      div_q <= '0;
      cnt_o <= '0;
    end else if (tick) begin
      div_q <= '0;
      cnt_o <= (cnt_o >= arr_i) ? '0 : cnt_o + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  // counter only moves on a divider tick
  assert_hold_between_ticks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(clr_i) && !$past(tick)) |-> (cnt_o == $past(cnt_o)));
endmodule

// File: rtl/pwm_cap_edge_div.sv
`timescale 1ns/1ps
module pwm_cap_edge_div (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic       edge_i,
  input  logic [1:0] code_i,
  output logic       take_o
);
  logic [2:0] ecnt_q;
  logic [2:0] mask;

  assign mask   = (3'd1 << code_i) - 3'd1;
  assign take_o = en_i & edge_i & (ecnt_q == 3'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               ecnt_q <= '0;
    else if (clr_i)            ecnt_q <= '0;
    else if (en_i && edge_i)   ecnt_q <= (ecnt_q + 3'd1) & mask;
  end
endmodule

// File: rtl/pwm_cap_diff.sv
`timescale 1ns/1ps
module pwm_cap_diff #(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0] top_i,
  input  logic [CNT_W-1:0] early_i,
  input  logic [CNT_W-1:0] late_i,
  output logic [CNT_W-1:0] diff_o
);
  localparam int unsigned EXT_W = CNT_W + 1;
  logic [EXT_W-1:0] modulus, sum;

  always_comb begin
    modulus = {1'b0, top_i} + EXT_W'(1);
    if (late_i >= early_i) sum = {1'b0, late_i} - {1'b0, early_i};
    else                   sum = modulus - {1'b0, early_i} + {1'b0, late_i};
    diff_o = sum[CNT_W-1:0];
  end
endmodule

// File: rtl/pwm_capture.sv
`timescale 1ns/1ps
module pwm_capture
  import pwm_cap_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             sel_i,
  input  logic             pin0_i,
  input  logic             pin1_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [CNT_W-1:0] arr_i,
  input  logic [1:0]       icpsc_i,
  output logic             snap_valid_o,
  output logic [CNT_W-1:0] snap_rise_o,
  output logic [CNT_W-1:0] snap_fall_o,
  output logic             done_o,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] duty_o
);
  cap_state_e         st_q;
  logic [CNT_W-1:0]   cnt, t0_q, fall_q;
  logic [CNT_W-1:0]   per_raw, dty_raw, dty_fix;
  logic               rise, fall, armed;
  logic [NUM_CH-1:0]  edges, takes;

  assign armed = (st_q == ST_REF) || (st_q == ST_END);
  assign edges = {fall, rise};

  pwm_cap_edge u_edge (
    .clk_i (clk_i), .rst_ni (rst_ni), .sel_i (sel_i),
    .pin_i ({pin1_i, pin0_i}), .rise_o (rise), .fall_o (fall)
  );

  pwm_cap_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_tb (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (start_i),
    .psc_i (psc_i), .arr_i (arr_i), .cnt_o (cnt)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_div
    pwm_cap_edge_div u_div (
      .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (start_i), .en_i (armed),
      .edge_i (edges[ch]), .code_i (icpsc_i), .take_o (takes[ch])
    );
  end

  pwm_cap_diff #(.CNT_W(CNT_W)) u_per (
    .top_i (arr_i), .early_i (t0_q), .late_i (cnt), .diff_o (per_raw)
  );

  pwm_cap_diff #(.CNT_W(CNT_W)) u_dty (
    .top_i (arr_i), .early_i (t0_q), .late_i (fall_q), .diff_o (dty_raw)
  );

  // stale falling capture: remove one period
  assign dty_fix = (dty_raw > per_raw) ? dty_raw - per_raw : dty_raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      t0_q         <= '0;
      fall_q       <= '0;
      snap_valid_o <= 1'b0;
      snap_rise_o  <= '0;
      snap_fall_o  <= '0;
      period_o     <= '0;
      duty_o       <= '0;
    end else begin
      snap_valid_o <= 1'b0;
      if (start_i) begin
        st_q   <= ST_REF;
        fall_q <= '0;
      end else begin
        if (takes[1]) fall_q <= cnt;
        if (takes[0]) begin
          snap_valid_o <= 1'b1;
          snap_rise_o  <= cnt;
          snap_fall_o  <= fall_q;
          if (st_q == ST_REF) begin
            t0_q <= cnt;
            st_q <= ST_END;
          end else begin
            period_o <= per_raw;
            duty_o   <= dty_fix;
            st_q     <= ST_DONE;
          end
        end
      end
    end
  end

  assign done_o = (st_q == ST_DONE);

  assert_done_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(period_o) && $stable(duty_o)));

  assert_quiet_after_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(done_o) && !$past(start_i)) |-> !snap_valid_o);

  assert_done_with_pair_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> snap_valid_o);

  assert_period_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $stable(arr_i)) |-> (period_o <= arr_i));

  assert_start_clears_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o);
endmodule

// File: tb/pwm_capture_test.sv
`timescale 1ns/1ps
module pwm_capture_test;
  localparam int CNT_W = 16;
  localparam int PSC_W = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic sel_i = 1'b0;
  logic wave = 1'b0;
  logic noise = 1'b0;
  logic [PSC_W-1:0] psc_i = '0;
  logic [CNT_W-1:0] arr_i = 16'd255;
  logic [1:0] icpsc_i = '0;
  logic pin0_i, pin1_i;
  logic snap_valid_o, done_o;
  logic [CNT_W-1:0] snap_rise_o, snap_fall_o, period_o, duty_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int nsnap = 0;
  int sr [4];
  int sf [4];

  always #4 clk_i = ~clk_i;

  assign pin0_i = sel_i ? noise : wave;
  assign pin1_i = sel_i ? wave : noise;

  pwm_capture #(.CNT_W(CNT_W), .PSC_W(PSC_W)) uut (
    .clk_i, .rst_ni, .start_i, .sel_i, .pin0_i, .pin1_i, .psc_i, .arr_i,
    .icpsc_i, .snap_valid_o, .snap_rise_o, .snap_fall_o, .done_o,
    .period_o, .duty_o
  );

  always @(negedge clk_i) begin
    noise <= ~noise;
    if (snap_valid_o) begin
      if (nsnap < 4) begin
        sr[nsnap] = int'(snap_rise_o);
        sf[nsnap] = int'(snap_fall_o);
      end
      nsnap = nsnap + 1;
    end
  end

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 190000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_period(int nn, int pt, int arr);
    return (nn * pt) % (arr + 1);
  endfunction

  function automatic int exp_duty(int nn, int pt, int ht, int arr);
    int per = (nn * pt) % (arr + 1);
    int d = ht % (arr + 1);
    if (d > per) d = d - per;
    return d;
  endfunction

  task automatic one_period(input int p, input int h);
    wave = 1'b1;
    repeat (h) @(negedge clk_i);
    wave = 1'b0;
    repeat (p - h) @(negedge clk_i);
  endtask

  // pt/ht in counter ticks; the wave starts low after start
  task automatic run_case(input logic sel, input int pt, input int ht,
                          input int code, input int psc, input int arr);
    int nn = 1 << code;
    int p = pt * (psc + 1);
    int h = ht * (psc + 1);
    int m = arr + 1;
    int per_e, dty_e;
    @(negedge clk_i);
    wave = 1'b0;
    sel_i = sel;
    psc_i = PSC_W'(psc);
    arr_i = CNT_W'(arr);
    icpsc_i = 2'(code);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    nsnap = 0;
    check("R11 done cleared by start", int'(done_o), 0);
    repeat (6) @(negedge clk_i);
    for (int k = 0; k < nn + 2; k++) one_period(p, h);
    per_e = exp_period(nn, pt, arr);
    dty_e = exp_duty(nn, pt, ht, arr);
    check("R5 done after second pair", int'(done_o), 1);
    check("R5 snapshot count", nsnap, 2);
    check("R2/R6/R9 period", int'(period_o), per_e);
    check("R7/R8 duty", int'(duty_o), dty_e);
    if (nsnap >= 2) begin
      check("R3 rise snapshot spacing", (sr[1] - sr[0] + m) % m, per_e);
      check("R3 fall snapshot offset", (sf[1] - sr[0] + m) % m, ht % m);
    end
    for (int k = 0; k < 2; k++) one_period(p, h);
    check("R10 period held", int'(period_o), per_e);
    check("R10 duty held", int'(duty_o), dty_e);
    check("R10 no extra snapshots", nsnap, 2);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    check("R1 done at reset", int'(done_o), 0);
    check("R1 snap_valid at reset", int'(snap_valid_o), 0);
    check("R1 period at reset", int'(period_o), 0);
    check("R1 duty at reset", int'(duty_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R1 idle after reset", int'(done_o), 0);

    run_case(1'b0, 20, 7, 0, 0, 255);   // R3 basic, pin0
    run_case(1'b1, 20, 7, 0, 0, 255);   // R4 pin1 selected
    run_case(1'b0, 35, 10, 0, 0, 40);   // R6 period wraps
    run_case(1'b0, 35, 33, 0, 0, 40);   // R7 duty wraps
    run_case(1'b0, 130, 80, 0, 0, 99);  // R8 duty > period
    run_case(1'b1, 12, 5, 0, 3, 255);   // R2 prescaler 4
    run_case(1'b0, 9, 4, 3, 0, 255);    // R9 every 8th edge
    run_case(1'b1, 9, 2, 2, 1, 30);     // R9 every 4th with wrap

    for (int i = 0; i < 10; i++) begin
      int pt = 2 + int'($urandom_range(0, 58));
      int ht = 1 + int'($urandom_range(0, pt - 2));
      run_case(1'($urandom_range(0, 1)), pt, ht,
               int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
               20 + int'($urandom_range(0, 235)));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule